// File: doc/BRIEF.md
# Multi-Width Aliased General Register File

This block is a sixteen-entry general register file built from 16-bit words. The same storage can be reached through four views of different widths: single bytes, whole words, 32-bit pairs of adjacent words and 64-bit groups of four adjacent words. Every view aliases the one word array, so a value written through any view can be read back through every other view that covers the same bits.

The block has one combinational read port and one clocked write port. Each port takes a 4-bit register index and a 2-bit size code. A write changes only the bits that its view covers. Read data is always returned right-aligned in a 64-bit bus with zero fill. Instruction decode, flags and arithmetic sit outside the block.

Top module: `regfile_multiview`

## Requirements
- R1: While reset (rst_n low) is asserted, and after its release, every word holds zero. A word read of any index returns 0.
- R2: Size code 2'b01 selects the word view. The index 0..15 picks one 16-bit word, and a read returns it in rdata[15:0] with rdata[63:16] zero.
- R3: Size code 2'b00 selects the byte view. Index 0..7 picks bits 15:8 of word 0..7, and index 8..15 picks bits 7:0 of word (index-8). A read returns the byte in rdata[7:0] with all upper bits zero, and a write takes its byte from wdata[7:0].
- R4: A byte write changes only the addressed half of its word. The other half of that word and every other word are left unchanged.
- R5: Size code 2'b10 selects the pair view. Index bit 0 is ignored, so the pair starts at word 2k. Word 2k maps to bits 31:16 and word 2k+1 maps to bits 15:0. Bits 63:32 read as zero.
- R6: Size code 2'b11 selects the quad view. Index bits 1:0 are ignored, so the quad starts at word 4k. Word 4k maps to bits 63:48, word 4k+1 to bits 47:32, word 4k+2 to bits 31:16 and word 4k+3 to bits 15:0.
- R7: All views share one storage. Data written through any view reads back, through any other view, from the bit positions that R2, R3, R5 and R6 define.
- R8: The storage changes only on a rising clock edge with we high. With we low, all words keep their values.
- R9: A write touches exactly the words that its view covers: one word for a byte or word write, two words for a pair write and four words for a quad write.
- R10: Reads are combinational. rdata follows raddr and rsize within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes happen on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears every word |
| we | input | 1 | Write enable |
| waddr | input | 4 | Write register index |
| wsize | input | 2 | Write view: 00 byte, 01 word, 10 pair, 11 quad |
| wdata | input | 64 | Write data, right-aligned for the chosen view |
| raddr | input | 4 | Read register index |
| rsize | input | 2 | Read view, same encoding as wsize |
| rdata | output | 64 | Read data, right-aligned and zero-extended |

## Verification
The assertions assume that clk runs freely and that rst_n is released away from a clock edge. Every index and size code is legal, so they make no further assumption about the write or read inputs. Given that, each write cycle must enable one, two or four word lanes according to its size, and any lane left disabled must hold its value. The stimulus releases reset on a falling edge and changes inputs only on falling edges. It mixes directed aliasing sequences with random indices, sizes and data, including index bits that the pair and quad views ignore.

// File: rtl/rfmv_pkg.sv
package rfmv_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_PAIR = 2'b10,
    SZ_QUAD = 2'b11
  } view_size_e;
endpackage

// File: rtl/rfmv_write_lanes.sv
module rfmv_write_lanes #(
  parameter int NUM_WORDS = 16,
  parameter int WORD_W    = 16,
  localparam int IDX_W    = $clog2(NUM_WORDS),
  localparam int HALF_W   = WORD_W / 2,
  localparam int BUS_W    = 4 * WORD_W
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [IDX_W-1:0]                   waddr,
  input  logic [1:0]                         wsize,
  input  logic [BUS_W-1:0]                   wdata,
  output logic [NUM_WORDS-1:0]               hi_we,
  output logic [NUM_WORDS-1:0]               lo_we,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]   lane_data
);
  import rfmv_pkg::*;

  logic [NUM_WORDS-1:0] lane_hit;

  // Slice of the write bus that lands in word lane 'pos' of a multi-word view.
  function automatic logic [WORD_W-1:0] group_slice(input logic [BUS_W-1:0] bus,
                                                    input int unsigned width_words,
                                                    input int unsigned pos);
    int unsigned shift;
    shift = (width_words - 1 - pos) * WORD_W;
    return bus[shift +: WORD_W];
  endfunction

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_lane
    localparam logic [IDX_W-1:0] LANE = i[IDX_W-1:0];
    logic hit, hi_sel, lo_sel;
    logic [WORD_W-1:0] val;
    always_comb begin
      hit    = 1'b0;
      hi_sel = 1'b0;
      lo_sel = 1'b0;
      val    = '0;
      unique case (view_size_e'(wsize))
        SZ_BYTE: begin
          hit    = (LANE[IDX_W-1] == 1'b0) && (waddr[IDX_W-2:0] == LANE[IDX_W-2:0]);
          hi_sel = hit && !waddr[IDX_W-1];
          lo_sel = hit &&  waddr[IDX_W-1];
          val    = {wdata[HALF_W-1:0], wdata[HALF_W-1:0]};
        end
        SZ_WORD: begin
          hit = (waddr == LANE);
          hi_sel = hit;
          lo_sel = hit;
          val = wdata[WORD_W-1:0];
        end
        SZ_PAIR: begin
          hit = (waddr[IDX_W-1:1] == LANE[IDX_W-1:1]);
          hi_sel = hit;
          lo_sel = hit;
          val = group_slice(wdata, 2, int'(LANE[0]));
        end
        default: begin
          hit = (waddr[IDX_W-1:2] == LANE[IDX_W-1:2]);
          hi_sel = hit;
          lo_sel = hit;
          val = group_slice(wdata, 4, int'(LANE[1:0]));
        end
      endcase
    end
    assign lane_hit[i]  = we && hit;
    assign hi_we[i]     = we && hi_sel;
    assign lo_we[i]     = we && lo_sel;
    assign lane_data[i] = val;
  end

  assert_lane_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ($countones(lane_hit) ==
            ((wsize == 2'b11) ? 4 : (wsize == 2'b10) ? 2 : 1)));

  assert_byte_one_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wsize == 2'b00) |-> ($countones(hi_we) + $countones(lo_we) == 1));
endmodule

// File: rtl/rfmv_word_bank.sv
module rfmv_word_bank #(
  parameter int NUM_WORDS = 16,
  parameter int WORD_W    = 16,
  localparam int HALF_W   = WORD_W / 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_WORDS-1:0]             hi_we,
  input  logic [NUM_WORDS-1:0]             lo_we,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] lane_data,
  output logic [NUM_WORDS-1:0][WORD_W-1:0] words
);
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    logic [HALF_W-1:0] hi_q, lo_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q <= '0;
        lo_q <= '0;
      end else begin
        if (hi_we[i]) hi_q <= lane_data[i][WORD_W-1:HALF_W];
        if (lo_we[i]) lo_q <= lane_data[i][HALF_W-1:0];
      end
    end
    assign words[i] = {hi_q, lo_q};

    assert_idle_word_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_we[i] || lo_we[i]) |=> $stable(words[i]));
    assert_low_half_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_we[i] && !lo_we[i]) |=> $stable(words[i][HALF_W-1:0]));
    assert_high_half_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_we[i] && !hi_we[i]) |=> $stable(words[i][WORD_W-1:HALF_W]));
  end
endmodule

// File: rtl/rfmv_read_view.sv
module rfmv_read_view #(
  parameter int NUM_WORDS = 16,
  parameter int WORD_W    = 16,
  localparam int IDX_W    = $clog2(NUM_WORDS),
  localparam int HALF_W   = WORD_W / 2,
  localparam int BUS_W    = 4 * WORD_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] words,
  input  logic [IDX_W-1:0]                 raddr,
  input  logic [1:0]                       rsize,
  output logic [BUS_W-1:0]                 rdata
);
  import rfmv_pkg::*;

  logic [IDX_W-1:0] pair_base, quad_base, byte_word;

  function automatic logic [BUS_W-1:0] gather(input logic [NUM_WORDS-1:0][WORD_W-1:0] w,
                                              input logic [IDX_W-1:0] base,
                                              input int unsigned count);
    logic [BUS_W-1:0] acc;
    acc = '0;
    for (int unsigned k = 0; k < 4; k++) begin
      if (k < count) acc = (acc << WORD_W) | BUS_W'(w[base + IDX_W'(k)]);
    end
    return acc;
  endfunction

  assign pair_base = {raddr[IDX_W-1:1], 1'b0};
  assign quad_base = {raddr[IDX_W-1:2], 2'b00};
  assign byte_word = {1'b0, raddr[IDX_W-2:0]};

  always_comb begin
    unique case (view_size_e'(rsize))
      SZ_BYTE: rdata = raddr[IDX_W-1] ? BUS_W'(words[byte_word][HALF_W-1:0])
                                      : BUS_W'(words[byte_word][WORD_W-1:HALF_W]);
      SZ_WORD: rdata = BUS_W'(words[raddr]);
      SZ_PAIR: rdata = gather(words, pair_base, 2);
      default: rdata = gather(words, quad_base, 4);
    endcase
  end

  assert_byte_zero_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsize == 2'b00) |-> (rdata[BUS_W-1:HALF_W] == '0));
  assert_pair_zero_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsize == 2'b10) |-> (rdata[BUS_W-1:2*WORD_W] == '0));
endmodule

// File: rtl/regfile_multiview.sv
module regfile_multiview #(
  parameter int NUM_WORDS = 16,
  parameter int WORD_W    = 16,
  localparam int IDX_W    = $clog2(NUM_WORDS),
  localparam int BUS_W    = 4 * WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [1:0]       wsize,
  input  logic [BUS_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  input  logic [1:0]       rsize,
  output logic [BUS_W-1:0] rdata
);
  logic [NUM_WORDS-1:0]             hi_we, lo_we;
  logic [NUM_WORDS-1:0][WORD_W-1:0] lane_data;
  logic [NUM_WORDS-1:0][WORD_W-1:0] words;

  rfmv_write_lanes #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wsize(wsize), .wdata(wdata),
    .hi_we(hi_we), .lo_we(lo_we), .lane_data(lane_data)
  );

  rfmv_word_bank #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .hi_we(hi_we), .lo_we(lo_we),
    .lane_data(lane_data), .words(words)
  );

  rfmv_read_view #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .words(words), .raddr(raddr), .rsize(rsize), .rdata(rdata)
  );

  assert_no_write_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |-> (hi_we == '0 && lo_we == '0));
endmodule

// File: tb/regfile_multiview_tb.sv
`timescale 1ns/1ps
module regfile_multiview_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  waddr = '0;
  logic [1:0]  wsize = '0;
  logic [63:0] wdata = '0;
  logic [3:0]  raddr = '0;
  logic [1:0]  rsize = '0;
  logic [63:0] rdata;

  int checks = 0;
  int failures = 0;
  logic [15:0] mdl [16];

  always #2.5 clk = ~clk;

  regfile_multiview u_dut (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wsize(wsize), .wdata(wdata),
    .raddr(raddr), .rsize(rsize), .rdata(rdata)
  );

  function automatic logic [63:0] model_read(input int idx, input int sz);
    logic [63:0] acc;
    int base;
    acc = 64'd0;
    case (sz)
      0: acc = (idx < 8) ? {56'd0, mdl[idx][15:8]} : {56'd0, mdl[idx - 8][7:0]};
      1: acc = {48'd0, mdl[idx]};
      2: begin base = (idx / 2) * 2; acc = {32'd0, mdl[base], mdl[base + 1]}; end
      default: begin
        base = (idx / 4) * 4;
        for (int k = 0; k < 4; k++) acc = (acc << 16) | {48'd0, mdl[base + k]};
      end
    endcase
    return acc;
  endfunction

  task automatic model_write(input int idx, input int sz, input logic [63:0] d);
    int base;
    case (sz)
      0: if (idx < 8) mdl[idx][15:8] = d[7:0]; else mdl[idx - 8][7:0] = d[7:0];
      1: mdl[idx] = d[15:0];
      2: begin base = (idx / 2) * 2; mdl[base] = d[31:16]; mdl[base + 1] = d[15:0]; end
      default: begin
        base = (idx / 4) * 4;
        for (int k = 0; k < 4; k++) mdl[base + k] = d[63 - 16 * k -: 16];
      end
    endcase
  endtask

  function automatic string tag_of(input int sz);
    case (sz)
      0: return "R3";
      1: return "R2";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] exp);
    checks++;
    if (rdata !== exp) begin
      failures++;
      $display("FAIL %s raddr=%0d rsize=%0d actual=%h expected=%h", req, raddr, rsize, rdata, exp);
    end
  endtask

  // One clock: drive after the falling edge, compare the combinational read,
  // then let the rising edge commit the write in both design and model.
  task automatic cyc(input logic w, input int wa, input int ws, input logic [63:0] wd,
                     input int ra, input int rs, input string req);
    @(negedge clk);
    we = w; waddr = 4'(wa); wsize = 2'(ws); wdata = wd;
    raddr = 4'(ra); rsize = 2'(rs);
    #1;
    check(req, model_read(ra, rs));
    @(posedge clk);
    if (w) model_write(wa, ws, wd);
  endtask

  task automatic sweep_words(input string req);
    for (int i = 0; i < 16; i++) cyc(1'b0, 0, 0, 64'd0, i, 1, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 16'h0;
    repeat (3) @(negedge clk);
    #1;
    raddr = 4'd5; rsize = 2'd1;
    #1;
    check("R1", 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    sweep_words("R1");

    // word view, then byte and pair/quad reads of the same storage
    for (int i = 0; i < 16; i++) cyc(1'b1, i, 1, 64'(16'hA000 + 16'(i * 16'h0111)), i, 1, "R2");
    sweep_words("R2");
    for (int i = 0; i < 16; i++) cyc(1'b0, 0, 0, 64'd0, i, 0, "R7");
    for (int i = 0; i < 16; i++) cyc(1'b0, 0, 0, 64'd0, i, 2, "R5");
    for (int i = 0; i < 16; i++) cyc(1'b0, 0, 0, 64'd0, i, 3, "R6");

    // byte writes to both halves, neighbours must survive
    cyc(1'b1, 3, 0, 64'hFFFF_FFFF_FFFF_FF5A, 3, 1, "R4");
    cyc(1'b1, 12, 0, 64'h0000_0000_0000_00C3, 3, 1, "R4");
    cyc(1'b0, 0, 0, 64'd0, 4, 1, "R4");
    cyc(1'b0, 0, 0, 64'd0, 3, 0, "R3");
    cyc(1'b0, 0, 0, 64'd0, 11, 0, "R3");
    sweep_words("R4");

    // pair write with odd index, quad write with index 4k+3
    cyc(1'b1, 7, 2, 64'h1111_2222_DEAD_BEEF, 6, 1, "R5");
    cyc(1'b1, 11, 3, 64'h0123_4567_89AB_CDEF, 7, 1, "R5");
    cyc(1'b0, 0, 0, 64'd0, 8, 1, "R6");
    cyc(1'b0, 0, 0, 64'd0, 10, 2, "R6");
    cyc(1'b0, 0, 0, 64'd0, 8, 0, "R7");
    cyc(1'b0, 0, 0, 64'd0, 15, 0, "R7");
    sweep_words("R9");

    // write enable low: nothing may change
    for (int i = 0; i < 16; i++) cyc(1'b0, i, 3, 64'hFFFF_FFFF_FFFF_FFFF, i, 3, "R8");
    sweep_words("R8");

    // read follows address with no clock edge
    @(negedge clk);
    we = 1'b0; raddr = 4'd9; rsize = 2'd1;
    #0.5; check("R10", model_read(9, 1));
    raddr = 4'd2; rsize = 2'd3;
    #0.5; check("R10", model_read(2, 3));

    // random mix
    for (int n = 0; n < 600; n++) begin
      int rs;
      rs = int'($urandom_range(0, 3));
      cyc(1'($urandom_range(0, 1)), int'($urandom_range(0, 15)), int'($urandom_range(0, 3)),
          {$urandom, $urandom}, int'($urandom_range(0, 15)), rs, tag_of(rs));
    end
    sweep_words("R7");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule